// File: doc/BRIEF.md
# Transmit IP Length Checker

This block sits beside the transmit path of an Ethernet MAC. It watches an outgoing frame as a byte-wide stream with a valid strobe and an end-of-frame marker. It reads the EtherType at frame bytes 12 and 13, which are sent most significant byte first. For IPv4 (0x0800) and IPv6 (0x86DD) it compares the lengths that the IP header declares against the byte counts that the application actually supplies.

The application drives a header-mark input high on each byte that it considers part of the IP header. Header bytes are the marked bytes at frame offset 14 or later. Payload bytes are the unmarked bytes at offset 14 or later. The block reads these fields by frame offset:

- The version nibble and the header-length nibble come from byte 14 (upper and lower nibble).
- The IPv4 total length comes from bytes 16 and 17.
- The IPv6 payload length comes from bytes 18 and 19.

The header length counts 32-bit words. On the cycle after the last byte, the block raises a one-cycle status pulse. The status word carries a header-error bit, a payload-error bit, the eight MAC error inputs captured with the last byte, and a summary bit that ORs all of them.

Top module: `tx_iplen_check`

## Requirements
- R1: `stat_valid` is high for exactly the one cycle after a byte with `in_valid` and `in_last` both high, and otherwise low. While `stat_valid` is low, `status` is all zeros, and both are zero after reset.
- R2: For an IPv4 frame, `status[16]` (header error) is set when the count of marked header bytes differs from 4 times the header-length nibble.
- R3: For an IPv4 frame, `status[16]` is set when the header-length nibble is below 5.
- R4: For an IPv6 frame, `status[16]` is set when the count of marked header bytes is not 40.
- R5: `status[16]` is set when the EtherType is 0x0800 and the version nibble is not 4, or when the EtherType is 0x86DD and the version nibble is not 6.
- R6: For an IPv4 frame, `status[12]` (payload error) is set when the count of unmarked bytes from offset 14 on differs from the total length minus 4 times the header-length nibble. A total length smaller than the header length always gives an error.
- R7: For an IPv6 frame, `status[12]` is set when the payload byte count differs from the payload-length field.
- R8: Frames with any other EtherType never set `status[16]` or `status[12]`.
- R9: `status[15]` is the OR of `status[16]`, `status[12]` and all eight MAC error inputs captured with the last byte.
- R10: The MAC error inputs captured with the last byte appear at fixed status positions, with every other status bit zero:
  - `ext_err[0]` (jabber) goes to bit 14.
  - `ext_err[1]` (flush) goes to bit 13.
  - `ext_err[2]` (loss of carrier) goes to bit 11.
  - `ext_err[3]` (no carrier) goes to bit 10.
  - `ext_err[4]` (late collision) goes to bit 9.
  - `ext_err[5]` (excessive collision) goes to bit 8.
  - `ext_err[6]` (excessive deferral) goes to bit 2.
  - `ext_err[7]` (underflow) goes to bit 1.
- R11: Each frame is judged on its own. Idle cycles inside a frame are ignored. A frame that starts on the cycle right after the previous frame's last byte restarts all counts and fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_hdr | input | 1 | Marks the byte as part of the IP header |
| ext_err | input | 8 | MAC error flags, sampled with the last byte |
| stat_valid | output | 1 | One-cycle status pulse |
| status | output | 17 | Status word, valid while stat_valid is high |

## Verification
The bench builds the block with its default 16-bit counter width. This matches the 16-bit length fields, so every declared length can be compared exactly. Short frames of a few dozen bytes reach every error path:
- header-length nibbles above and below 5;
- a total length smaller than the header;
- EtherType and version mismatches in both directions.

Back-to-back frames and mid-frame idle cycles confirm that the per-frame state restarts cleanly.

// File: rtl/tx_iplen_check.sv
module tx_iplen_check #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_hdr,
  input  logic [7:0]  ext_err,
  output logic        stat_valid,
  output logic [16:0] status
);
  localparam int ETH_HDR = 14;
  localparam int V6_HDR  = 40;
  localparam int XW      = (CNT_W > 16 ? CNT_W : 16) + 1;

  logic [CNT_W-1:0] pos, idx, hcnt, pcnt, hbase, pbase;
  logic             first, done;
  logic [15:0]      etype, tot, plen;
  logic [3:0]       vnib, ihl;
  logic [7:0]       ext_q;

  assign idx   = first ? '0 : pos;
  assign hbase = first ? '0 : hcnt;
  assign pbase = first ? '0 : pcnt;

  wire past_eth = idx >= CNT_W'(ETH_HDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; first <= 1'b1; done <= 1'b0;
      etype <= '0; tot <= '0; plen <= '0; vnib <= '0; ihl <= '0;
      hcnt <= '0; pcnt <= '0; ext_q <= '0;
    end else begin
      done <= in_valid && in_last;
      if (in_valid) begin
        first <= in_last;
        pos   <= (&idx) ? idx : idx + 1'b1;
        if (first) begin
          etype <= '0; tot <= '0; plen <= '0; vnib <= '0; ihl <= '0;
        end
        if (idx == CNT_W'(12)) etype[15:8] <= in_data;
        if (idx == CNT_W'(13)) etype[7:0]  <= in_data;
        if (idx == CNT_W'(14)) begin vnib <= in_data[7:4]; ihl <= in_data[3:0]; end
        if (idx == CNT_W'(16)) tot[15:8]   <= in_data;
        if (idx == CNT_W'(17)) tot[7:0]    <= in_data;
        if (idx == CNT_W'(18)) plen[15:8]  <= in_data;
        if (idx == CNT_W'(19)) plen[7:0]   <= in_data;
        hcnt <= (past_eth && in_hdr && !(&hbase)) ? hbase + 1'b1 : hbase;
        pcnt <= (past_eth && !in_hdr && !(&pbase)) ? pbase + 1'b1 : pbase;
        if (in_last) ext_q <= ext_err;
      end
    end
  end

  wire is_v4 = etype == 16'h0800;
  wire is_v6 = etype == 16'h86DD;

  logic [XW-1:0] hx, px, hdr4, pay4;
  assign hx   = XW'(hcnt);
  assign px   = XW'(pcnt);
  assign hdr4 = XW'({ihl, 2'b00});
  assign pay4 = XW'(tot) - hdr4;

  wire hdr_err = (is_v4 && (vnib != 4'd4 || ihl < 4'd5 || hx != hdr4)) ||
                 (is_v6 && (vnib != 4'd6 || hx != XW'(V6_HDR)));
  wire pay_err = (is_v4 && px != pay4) || (is_v6 && px != XW'(plen));
  wire summary = hdr_err || pay_err || (|ext_q);

  assign stat_valid = done;
  assign status = done ? {hdr_err, summary, ext_q[0], ext_q[1], pay_err,
                          ext_q[2], ext_q[3], ext_q[4], ext_q[5],
                          5'b0, ext_q[6], ext_q[7], 1'b0} : 17'b0;

  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> stat_valid);
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_valid |-> status == 17'b0);
  assert_nonip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !is_v4 && !is_v6) |-> (!status[16] && !status[12]));
  assert_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> status[15] == (status[16] | status[14] | status[13] | status[12] |
                                  status[11] | status[10] | status[9] | status[8] |
                                  status[2] | status[1]));
  assert_jabber_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> status[14] == $past(ext_err[0]));
  assert_v6hdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && is_v6 && hcnt != CNT_W'(V6_HDR)) |-> status[16]);
endmodule

// File: tb/tx_iplen_check_tb.sv
module tx_iplen_check_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] et; logic [7:0] vb; logic [15:0] tot; logic [15:0] pl;
    logic [7:0] hc; logic [7:0] pc; logic [7:0] ext; logic eh; logic ep;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{16'h0800, 8'h45, 16'd30, 16'd0,  8'd20, 8'd10, 8'h00, 1'b0, 1'b0},
    '{16'h0800, 8'h45, 16'd30, 16'd0,  8'd24, 8'd10, 8'h00, 1'b1, 1'b0},
    '{16'h0800, 8'h46, 16'd32, 16'd0,  8'd24, 8'd8,  8'h00, 1'b0, 1'b0},
    '{16'h0800, 8'h44, 16'd20, 16'd0,  8'd16, 8'd4,  8'h00, 1'b1, 1'b0},
    '{16'h0800, 8'h45, 16'd30, 16'd0,  8'd20, 8'd11, 8'h00, 1'b0, 1'b1},
    '{16'h0800, 8'h65, 16'd30, 16'd0,  8'd20, 8'd10, 8'h00, 1'b1, 1'b0},
    '{16'h86DD, 8'h60, 16'd0,  16'd12, 8'd40, 8'd12, 8'h00, 1'b0, 1'b0},
    '{16'h86DD, 8'h60, 16'd0,  16'd12, 8'd39, 8'd12, 8'h00, 1'b1, 1'b0},
    '{16'h86DD, 8'h60, 16'd0,  16'd12, 8'd40, 8'd13, 8'h00, 1'b0, 1'b1},
    '{16'h86DD, 8'h45, 16'd0,  16'd12, 8'd40, 8'd12, 8'h00, 1'b1, 1'b0},
    '{16'h0806, 8'h45, 16'd99, 16'd7,  8'd5,  8'd3,  8'h00, 1'b0, 1'b0},
    '{16'h0800, 8'h45, 16'd30, 16'd0,  8'd20, 8'd10, 8'h81, 1'b0, 1'b0},
    '{16'h0800, 8'h45, 16'd10, 16'd0,  8'd20, 8'd0,  8'h00, 1'b0, 1'b1},
    '{16'h86DD, 8'h60, 16'd0,  16'd12, 8'd40, 8'd12, 8'h3C, 1'b0, 1'b0}
  };
  localparam string TAG [NV] = '{"R1", "R2", "R2", "R3", "R6", "R5", "R4",
                                 "R4", "R7", "R5", "R8", "R10", "R6", "R9"};

  logic clk = 0, rst_n = 0, in_valid = 0, in_last = 0, in_hdr = 0;
  logic [7:0] in_data = 0, ext_err = 0;
  logic stat_valid;
  logic [16:0] status;
  int checks = 0, failures = 0;
  bit finished = 0;

  tx_iplen_check dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_hdr(in_hdr), .ext_err(ext_err),
    .stat_valid(stat_valid), .status(status));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [16:0] exp_status(logic eh, logic ep, logic [7:0] e);
    logic [16:0] s = '0;
    s[16] = eh; s[12] = ep;
    s[14] = e[0]; s[13] = e[1]; s[11] = e[2]; s[10] = e[3];
    s[9] = e[4]; s[8] = e[5]; s[2] = e[6]; s[1] = e[7];
    s[15] = eh | ep | (|e);
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic send(vec_t v, bit bubble, bit samp, output logic pv, output logic [16:0] ps);
    int total = 14 + int'(v.hc) + int'(v.pc);
    pv = 0; ps = 0;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (i == 0 && samp) begin pv = stat_valid; ps = status; end
      if (bubble && i == 20) begin
        in_valid = 0; @(negedge clk);
      end
      in_valid = 1;
      in_last  = (i == total - 1);
      in_hdr   = (i >= 14 && i < 14 + int'(v.hc));
      ext_err  = in_last ? v.ext : 8'h00;
      if (i < 12) in_data = 8'hA0 | 8'(i);
      else if (i == 12) in_data = v.et[15:8];
      else if (i == 13) in_data = v.et[7:0];
      else if (!in_hdr) in_data = 8'h5A;
      else case (i)
        14: in_data = v.vb;
        16: in_data = v.tot[15:8];
        17: in_data = v.tot[7:0];
        18: in_data = v.pl[15:8];
        19: in_data = v.pl[7:0];
        default: in_data = 8'h00;
      endcase
    end
  endtask

  task automatic grab(output logic gv, output logic [16:0] gs);
    @(negedge clk);
    gv = stat_valid; gs = status;
    in_valid = 0; in_last = 0; in_hdr = 0; ext_err = 0;
  endtask

  task automatic run_one(vec_t v, string req, bit bubble);
    logic pv, gv; logic [16:0] ps, gs;
    send(v, bubble, 1'b0, pv, ps);
    grab(gv, gs);
    chk("R1 pulse", 32'(gv), 32'd1);
    chk(req, 32'(gs), 32'(exp_status(v.eh, v.ep, v.ext)));
    @(negedge clk);
    chk("R1 drop", 32'({stat_valid, status}), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic pv, gv; logic [16:0] ps, gs;
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R1 reset", 32'({stat_valid, status}), 32'd0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) run_one(VT[k], TAG[k], 1'b0);
    // R11: idle cycle inside frame
    run_one(VT[1], "R11 bubble", 1'b1);
    // R11: back-to-back frames, error frame then clean frame
    send(VT[7], 1'b0, 1'b0, pv, ps);
    send(VT[0], 1'b0, 1'b1, pv, ps);
    chk("R11 first valid", 32'(pv), 32'd1);
    chk("R11 first status", 32'(ps), 32'(exp_status(1'b1, 1'b0, 8'h00)));
    grab(gv, gs);
    chk("R11 second status", 32'(gs), 32'(exp_status(1'b0, 1'b0, 8'h00)));
    @(negedge clk);
    // R10 and R9: each MAC error input alone
    for (int b = 0; b < 8; b++) begin
      v = VT[0];
      v.ext = 8'(1 << b);
      run_one(v, "R10", 1'b0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule